// File: doc/BRIEF.md
# Function-Select GPIO Bank

This block is a bank of up to eight general-purpose pins behind a small word-addressed register port. Every pin carries a four-bit function code. The code makes the pin one of four things: a plain input, a push-pull output driven from a level register, a pad handed to an alternate on-chip function, or an input that can raise an interrupt. Software programs the function codes, the output levels and an interrupt mask, and reads back pin levels through the same level register.

On the pad side, the block takes the raw pad input and drives a registered pad output value and output enable. For pins handed to an alternate function, it routes that function's transmit bit to the pad. Every pad input passes through a two-flop synchroniser before the register readback, the interrupt logic or the alternate-function receive port can see it. A single level-sensitive interrupt is the OR of all unmasked, high pins that are in interrupt mode. The register read port is registered, so a read returns its data one clock after the address is presented.

Top module: `gpio_fsel_bank`

## Requirements
- R1: After reset all function codes are 0000 (input), the level register and the interrupt mask are zero, every pad output enable is low and the interrupt output is low.
- R2: The function register at byte offset 0x00 holds pin n's code in bits [4n+3:4n]. It is written whole and reads back what was written. Read data appears on the clock after the address is presented.
- R3: With code 0000 the pin's output enable is low. A level-register read (offset 0x04, bit n) returns the pad level once it has passed two synchronising flops.
- R4: With code 0001 the output enable is high and the pad output equals the level-register bit. A level-register read returns the driven value, not the pad.
- R5: Codes 0010 through 1110 raise the output enable, and the pad output follows the alternate-function transmit bit one clock later.
- R6: Code 1111 keeps the output enable low and makes the pin an interrupt source.
- R7: Pad output and output enable change on the same clock edge as the register write that changes them. A pin switched to output therefore presents the level written beforehand in its first enabled cycle.
- R8: The interrupt output is high exactly when some pin with code 1111 has a synchronised high level and its bit is set in the mask register at offset 0x08 (bit n for pin n). It is registered one clock behind the synchronised level and stays high while that condition holds.
- R9: With fewer than eight pins, the fields and bits of absent pins read as zero and ignore writes.
- R10: Reads of any offset other than 0x00, 0x04 and 0x08 return zero, and writes there change no register.
- R11: The alternate-function receive port presents each pad input delayed by exactly two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Registered pad output value |
| pad_oe | output | NUM_PINS | Registered pad output enable |
| alt_tx | input | NUM_PINS | Alternate-function transmit bits |
| alt_rx | output | NUM_PINS | Synchronised pad levels for alternate functions |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
A corrupted function code shows up on pad_oe in the very cycle after the write, because the enable is registered from the code's next value. It also shows up on any read of offset 0x00 one clock after the address. A wrong level bit is visible on pad_out for output pins at once, and on a readback one clock later. A fault in the synchroniser or the mask shifts or suppresses irq and alt_rx, and the directed sequences measure that at exactly two or three clocks after a pad change.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;

  localparam int unsigned FSEL_W = 4;
  localparam int unsigned BUS_W  = 32;

  localparam logic [FSEL_W-1:0] FS_INPUT  = 4'h0;
  localparam logic [FSEL_W-1:0] FS_OUTPUT = 4'h1;
  localparam logic [FSEL_W-1:0] FS_EXTINT = 4'hF;

  localparam logic [7:0] OFS_FSEL  = 8'h00;
  localparam logic [7:0] OFS_LEVEL = 8'h04;
  localparam logic [7:0] OFS_IMASK = 8'h08;

  typedef enum logic [1:0] {
    PM_IN  = 2'd0,
    PM_OUT = 2'd1,
    PM_ALT = 2'd2,
    PM_INT = 2'd3
  } pin_mode_e;

  function automatic pin_mode_e fsel_mode(input logic [FSEL_W-1:0] code);
    if (code == FS_INPUT)       return PM_IN;
    else if (code == FS_OUTPUT) return PM_OUT;
    else if (code == FS_EXTINT) return PM_INT;
    else                        return PM_ALT;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_we,
  input  logic [BUS_W-1:0]           reg_wdata,
  input  logic [NUM_PINS-1:0]        pin_rd,
  output logic [FSEL_W*NUM_PINS-1:0] fsel_q,
  output logic [FSEL_W*NUM_PINS-1:0] fsel_d,
  output logic [NUM_PINS-1:0]        level_q,
  output logic [NUM_PINS-1:0]        level_d,
  output logic [NUM_PINS-1:0]        mask_q,
  output logic [BUS_W-1:0]           reg_rdata
);

  localparam int unsigned CFG_W = FSEL_W * NUM_PINS;

  logic hit_fsel, hit_level, hit_mask;
  logic [NUM_PINS-1:0] mask_d;
  logic [BUS_W-1:0]    rd_mux;

  assign hit_fsel  = (reg_addr == ADDR_W'(OFS_FSEL));
  assign hit_level = (reg_addr == ADDR_W'(OFS_LEVEL));
  assign hit_mask  = (reg_addr == ADDR_W'(OFS_IMASK));

  always_comb begin
    fsel_d  = fsel_q;
    level_d = level_q;
    mask_d  = mask_q;
    if (reg_we) begin
      if (hit_fsel)  fsel_d  = reg_wdata[CFG_W-1:0];
      if (hit_level) level_d = reg_wdata[NUM_PINS-1:0];
      if (hit_mask)  mask_d  = reg_wdata[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_fsel)       rd_mux = BUS_W'(fsel_q);
    else if (hit_level) rd_mux = BUS_W'(pin_rd);
    else if (hit_mask)  rd_mux = BUS_W'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q    <= '0;
      level_q   <= '0;
      mask_q    <= '0;
      reg_rdata <= '0;
    end else begin
      fsel_q    <= fsel_d;
      level_q   <= level_d;
      mask_q    <= mask_d;
      reg_rdata <= rd_mux;
    end
  end

  // R10: an undecoded offset in the previous cycle yields zero read data
  p_undecoded_zero_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) != ADDR_W'(OFS_FSEL) && $past(reg_addr) != ADDR_W'(OFS_LEVEL) &&
     $past(reg_addr) != ADDR_W'(OFS_IMASK)) |-> (reg_rdata == '0));

endmodule

// File: rtl/gpio_fsel_pin.sv
module gpio_fsel_pin
  import gpio_fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FSEL_W-1:0] fsel_cur,
  input  logic [FSEL_W-1:0] fsel_nxt,
  input  logic              level_cur,
  input  logic              level_nxt,
  input  logic              alt_bit,
  input  logic              sync_lvl,
  output logic              pad_out_q,
  output logic              pad_oe_q,
  output logic              irq_src,
  output logic              rd_bit
);

  pin_mode_e mode_cur, mode_nxt;
  logic      out_nxt, oe_nxt;

  assign mode_cur = fsel_mode(fsel_cur);
  assign mode_nxt = fsel_mode(fsel_nxt);

  always_comb begin
    case (mode_nxt)
      PM_OUT:  begin oe_nxt = 1'b1; out_nxt = level_nxt; end
      PM_ALT:  begin oe_nxt = 1'b1; out_nxt = alt_bit;   end
      default: begin oe_nxt = 1'b0; out_nxt = level_nxt; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_q <= 1'b0;
      pad_oe_q  <= 1'b0;
    end else begin
      pad_out_q <= out_nxt;
      pad_oe_q  <= oe_nxt;
    end
  end

  assign irq_src = (mode_cur == PM_INT) && sync_lvl;
  assign rd_bit  = (mode_cur == PM_OUT) ? level_cur : sync_lvl;

  // R3: an input-mode pin never drives its pad
  p_input_no_drive_r3: assert property (@(posedge clk) disable iff (rst)
    (fsel_cur == FS_INPUT) |-> !pad_oe_q);

  // R6: an interrupt-mode pin never drives its pad
  p_extint_no_drive_r6: assert property (@(posedge clk) disable iff (rst)
    (fsel_cur == FS_EXTINT) |-> !pad_oe_q);

  // R4: an output pin drives the stored level
  p_output_drives_level_r4: assert property (@(posedge clk) disable iff (rst)
    (fsel_cur == FS_OUTPUT) |-> (pad_oe_q && pad_out_q == level_cur));

  // R7: the first enabled cycle of an output pin carries the current level
  p_first_cycle_fresh_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(pad_oe_q) && fsel_cur == FS_OUTPUT) |-> (pad_out_q == level_cur));

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] alt_tx,
  output logic [NUM_PINS-1:0] alt_rx,
  output logic                irq
);

  localparam int unsigned CFG_W = FSEL_W * NUM_PINS;

  logic [CFG_W-1:0]    fsel_q, fsel_d;
  logic [NUM_PINS-1:0] level_q, level_d, mask_q;
  logic [NUM_PINS-1:0] sync_lvl, pin_rd, irq_src;
  logic                irq_q;

  gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (sync_lvl)
  );

  gpio_fsel_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .pin_rd    (pin_rd),
    .fsel_q    (fsel_q),
    .fsel_d    (fsel_d),
    .level_q   (level_q),
    .level_d   (level_d),
    .mask_q    (mask_q),
    .reg_rdata (reg_rdata)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_fsel_pin u_pin (
      .clk       (clk),
      .rst       (rst),
      .fsel_cur  (fsel_q[FSEL_W*p +: FSEL_W]),
      .fsel_nxt  (fsel_d[FSEL_W*p +: FSEL_W]),
      .level_cur (level_q[p]),
      .level_nxt (level_d[p]),
      .alt_bit   (alt_tx[p]),
      .sync_lvl  (sync_lvl[p]),
      .pad_out_q (pad_out[p]),
      .pad_oe_q  (pad_oe[p]),
      .irq_src   (irq_src[p]),
      .rd_bit    (pin_rd[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(irq_src & mask_q);
  end

  assign irq    = irq_q;
  assign alt_rx = sync_lvl;

  // R8: a fully cleared mask one cycle earlier forbids an interrupt
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> !irq);

  // R8: no interrupt without a high synchronised pin the cycle before
  p_irq_needs_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(sync_lvl) != '0));

endmodule

// File: tb/tb_gpio_fsel_bank.sv
module tb_gpio_fsel_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata8, rdata5;
  logic [7:0]  pad_in = '0;
  logic [7:0]  alt_tx = '0;
  logic [7:0]  pad_out, pad_oe, alt_rx;
  logic        irq;
  logic [4:0]  pad_out5, pad_oe5, alt_rx5;
  logic        irq5;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_fsel_bank #(.NUM_PINS(8), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata8), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_tx(alt_tx), .alt_rx(alt_rx), .irq(irq)
  );

  gpio_fsel_bank #(.NUM_PINS(5), .ADDR_W(8)) dut5 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata5), .pad_in(pad_in[4:0]),
    .pad_out(pad_out5), .pad_oe(pad_oe5), .alt_tx(alt_tx[4:0]), .alt_rx(alt_rx5), .irq(irq5)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d8, output logic [31:0] d5);
    reg_addr = a;
    @(negedge clk);
    d8 = rdata8;
    d5 = rdata5;
  endtask

  task automatic test_reset();
    logic [31:0] a, b;
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    bus_read(8'h00, a, b); chk("R1 fsel", a, 32'h0);
    bus_read(8'h04, a, b); chk("R1 level", a, 32'h0);
    bus_read(8'h08, a, b); chk("R1 mask", a, 32'h0);
  endtask

  task automatic test_fsel_readback();
    logic [31:0] a, b;
    bus_write(8'h00, 32'h5A3C_E21F);
    bus_read(8'h00, a, b); chk("R2 fsel readback", a, 32'h5A3C_E21F);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, a, b); chk("R2 fsel cleared", a, 32'h0);
  endtask

  task automatic test_input_sync();
    logic [31:0] a, b;
    pad_in = 8'hA5;
    wait_cycles(1);
    chk("R11 alt_rx after one clock", {24'h0, alt_rx}, 32'h0);
    wait_cycles(1);
    chk("R11 alt_rx after two clocks", {24'h0, alt_rx}, 32'hA5);
    bus_read(8'h04, a, b); chk("R3 input level", a, 32'hA5);
    chk("R3 no drive", {24'h0, pad_oe}, 32'h0);
  endtask

  task automatic test_output();
    logic [31:0] a, b;
    bus_write(8'h04, 32'h3C);
    bus_write(8'h00, 32'h1111_1111);
    chk("R4 oe", {24'h0, pad_oe}, 32'hFF);
    chk("R4 pad_out", {24'h0, pad_out}, 32'h3C);
    pad_in = 8'hC3;
    wait_cycles(2);
    bus_read(8'h04, a, b); chk("R4 driven value read", a, 32'h3C);
  endtask

  task automatic test_fresh_switch();
    bus_write(8'h00, 32'h0);
    chk("R3 oe after return to input", {24'h0, pad_oe}, 32'h0);
    bus_write(8'h04, 32'hFF);
    chk("R7 no drive before switch", {24'h0, pad_oe}, 32'h0);
    bus_write(8'h00, 32'h0000_0100);
    chk("R7 first cycle oe", {24'h0, pad_oe}, 32'h04);
    chk("R7 first cycle level", {31'h0, pad_out[2]}, 32'h1);
  endtask

  task automatic test_alt();
    bus_write(8'h00, 32'h00E0_0020);
    chk("R5 alt oe", {24'h0, pad_oe}, 32'h22);
    alt_tx = 8'h22;
    wait_cycles(1);
    chk("R5 alt high", {24'h0, pad_out & 8'h22}, 32'h22);
    alt_tx = 8'h00;
    wait_cycles(1);
    chk("R5 alt low", {24'h0, pad_out & 8'h22}, 32'h0);
  endtask

  task automatic test_irq();
    pad_in = 8'h00;
    bus_write(8'h00, 32'h0F00_F000);
    chk("R6 extint no drive", {24'h0, pad_oe}, 32'h0);
    bus_write(8'h08, 32'h09);
    pad_in = 8'h40;
    wait_cycles(3);
    chk("R8 masked pin quiet", {31'h0, irq}, 32'h0);
    pad_in = 8'h01;
    wait_cycles(3);
    chk("R6 input-mode pin no irq", {31'h0, irq}, 32'h0);
    pad_in = 8'h48;
    wait_cycles(2);
    chk("R8 irq not before register stage", {31'h0, irq}, 32'h0);
    wait_cycles(1);
    chk("R8 irq raised", {31'h0, irq}, 32'h1);
    wait_cycles(4);
    chk("R8 irq held", {31'h0, irq}, 32'h1);
    pad_in = 8'h40;
    wait_cycles(3);
    chk("R8 irq cleared", {31'h0, irq}, 32'h0);
    bus_write(8'h08, 32'h0);
  endtask

  task automatic test_undecoded();
    logic [31:0] a, b;
    bus_write(8'h04, 32'h5A);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h0C, a, b); chk("R10 read 0x0C", a, 32'h0);
    bus_read(8'h10, a, b); chk("R10 read 0x10", a, 32'h0);
    bus_read(8'h00, a, b); chk("R10 fsel untouched", a, 32'h0F00_F000);
    bus_read(8'h08, a, b); chk("R10 mask untouched", a, 32'h0);
    bus_write(8'h00, 32'h1111_1111);
    chk("R10 level untouched", {24'h0, pad_out}, 32'h5A);
  endtask

  task automatic test_narrow();
    logic [31:0] a, b;
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h08, 32'hFF);
    pad_in = 8'hFF;
    wait_cycles(2);
    bus_read(8'h00, a, b); chk("R9 narrow fsel", b, 32'h000F_FFFF);
    bus_read(8'h08, a, b); chk("R9 narrow mask", b, 32'h1F);
    bus_read(8'h04, a, b); chk("R9 narrow level", b, 32'h1F);
    chk("R9 full-width level", a, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_fsel_readback();
    test_input_sync();
    test_output();
    test_fresh_switch();
    test_alt();
    test_irq();
    test_undecoded();
    test_narrow();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule